// File: doc/BRIEF.md
# 3x3 Matrix Cofactor and Determinant Unit

This block takes a 3x3 matrix of signed 8-bit integers and returns two things. The first is the determinant. The second is the nine entries of the adjugate, which are the numerators of the inverse matrix. A host places the matrix on `matIn` and pulses `start`. The unit latches the matrix and runs a fixed seven-step schedule. It then raises `done` for one cycle, with the determinant, the adjugate and a validity flag present on its outputs. The final division by the determinant is left to the consumer.

All arithmetic runs on a small shared pool of functional units: six multipliers, three subtractors and three adders. A controller steps through the schedule and the datapath routes operands into the pool.

The steps are used as follows:
- Steps 1 and 2 form the six triple products of the determinant as two-stage multiplier chains.
- The cofactor products are bound into three groups of three. Each group takes all six multipliers in its own step, which is step 3, 4 or 5.
- Each group's differences are taken by the three subtractors one step later.
- The determinant is reduced in the gaps that the subtractors leave.

The adjugate is published only when the determinant is strictly positive.

Top module: `mtxinv_core`

## Requirements
- R1: After reset, `done`, `invValid`, `detOut` and `adjOut` are all zero.
- R2: Entry (r,c) of the input matrix is read from `matIn` bits [8*(3r+c)+:8] as two's complement. It is sampled only at the rising edge that accepts `start`; later changes of `matIn` have no effect on that run's results.
- R3: When `start` is sampled high at a rising edge while the unit is idle, `done` is high for exactly one cycle. That cycle follows the 7th rising edge after the accepting edge. All outputs take their new values at that same 7th edge. During the `done` cycle the unit is idle again, so a `start` sampled at the end of that cycle is accepted.
- R4: A `start` sampled at any of the 7 rising edges that follow an accepting edge is ignored. It neither restarts nor extends the run, and it does not latch new inputs.
- R5: At every completion, `detOut` holds the exact determinant of the latched matrix as a 26-bit two's complement value.
- R6: If the determinant is strictly positive, `invValid` becomes 1. The adjugate entry (i,j) appears at `adjOut` bits [17*(3i+j)+:17] as 17-bit two's complement. Its value is the signed cofactor (j,i) of the input: (-1)^(i+j) times the 2x2 minor that remains after deleting row j and column i.
- R7: If the determinant is zero or negative, `invValid` becomes 0 and `adjOut` keeps the value it had before that completion.
- R8: Results are exact over the full input range, including every entry at -128 or 127; no intermediate product or sum wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a run; honoured only while idle |
| matIn | input | 72 | Nine signed 8-bit matrix entries, row-major |
| done | output | 1 | One-cycle pulse when results are published |
| invValid | output | 1 | Determinant of the last run was strictly positive |
| detOut | output | 26 | Determinant of the last run, signed |
| adjOut | output | 153 | Nine signed 17-bit adjugate entries, row-major |

## Verification
The interesting collision is the publication of one result and the acceptance of the next request at the same clock edge. In that cycle `done` is high, the unit has just gone idle, and a `start` already present is latched at the following edge. The bench provokes this by holding `start` high through a whole run, while also scrambling `matIn` during the busy window. The behavioural model then has to agree, cycle by cycle, on which matrix each back-to-back run used and on when each `done` pulse lands. A second overlap is the determinant sign decision and the adjugate write, which fall on the same edge. Runs with zero, negative and positive determinants are interleaved, so a held adjugate can be told apart from a freshly written one.

// File: rtl/mtxinv_pkg.sv
package mtxinv_pkg;

  localparam int NDIM  = 3;            // matrix order
  localparam int NENT  = NDIM * NDIM;  // entries per matrix
  localparam int NMUL  = 6;            // shared multipliers
  localparam int NSUB  = 3;            // shared subtractors
  localparam int NADD  = 3;            // shared adders
  localparam int NGRP  = 3;            // cofactor groups
  localparam int NSTEP = 7;            // control steps per run

  // step numbers of the fixed schedule
  localparam int STEP_PAIR = 1;        // first factor pair of each triple product
  localparam int STEP_TRI  = 2;        // triple products complete
  localparam int STEP_G0   = 3;        // first cofactor group multiplies

  typedef enum logic [1:0] {FU_MUL, FU_ADD, FU_SUB} fuKind_e;

  typedef struct packed {
    logic             load;     // accept inputs this cycle
    logic [NSTEP:1]   stepHot;  // one-hot active control step
  } ctrlStrb_t;

  // Triple-product operand indices: k 0..2 are positive terms, 3..5 negative.
  function automatic logic [3:0] triIdx(input int k, input int slot);
    logic [11:0] code;
    case (k)
      0:       code = 12'h048;
      1:       code = 12'h156;
      2:       code = 12'h237;
      3:       code = 12'h246;
      4:       code = 12'h057;
      default: code = 12'h138;
    endcase
    return 4'(code >> (4 * (2 - slot)));
  endfunction

  // Signed cofactor (r,c), index 3r+c, as m[s0]*m[s1] - m[s2]*m[s3].
  function automatic logic [3:0] cofIdx(input int cof, input int slot);
    logic [15:0] code;
    case (cof)
      0:       code = 16'h4857;
      1:       code = 16'h5638;
      2:       code = 16'h3746;
      3:       code = 16'h2718;
      4:       code = 16'h0826;
      5:       code = 16'h1607;
      6:       code = 16'h1524;
      7:       code = 16'h2305;
      default: code = 16'h0413;
    endcase
    return 4'(code >> (4 * (3 - slot)));
  endfunction

endpackage

// File: rtl/mtxinv_fu.sv
module mtxinv_fu
  import mtxinv_pkg::*;
#(
  parameter fuKind_e KIND = FU_ADD,
  parameter int      AW   = 8,
  parameter int      BW   = 8,
  parameter int      RW   = 8
) (
  input  logic signed [AW-1:0] opA,
  input  logic signed [BW-1:0] opB,
  output logic signed [RW-1:0] res
);

  if (KIND == FU_MUL) begin : g_mul
    assign res = RW'(opA) * RW'(opB);
  end else if (KIND == FU_SUB) begin : g_sub
    assign res = RW'(opA) - RW'(opB);
  end else begin : g_add
    assign res = RW'(opA) + RW'(opB);
  end

endmodule

// File: rtl/mtxinv_ctrl.sv
module mtxinv_ctrl
  import mtxinv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output ctrlStrb_t strb,
  output logic      done
);

  localparam int SW = $clog2(NSTEP + 1);

  logic [SW-1:0] stepCnt;
  logic          busy;

  assign busy = (stepCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (stepCnt == SW'(NSTEP));
      if (!busy) begin
        if (start) stepCnt <= SW'(1);
      end else if (stepCnt == SW'(NSTEP)) begin
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb      = '0;
    strb.load = !busy && start;
    for (int k = 1; k <= NSTEP; k++) begin
      strb.stepHot[k] = (stepCnt == SW'(k));
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.stepHot[NSTEP]) |=> (busy && !strb.load)); // R4

endmodule

// File: rtl/mtxinv_dpath.sv
module mtxinv_dpath
  import mtxinv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrb_t                 strb,
  input  logic [NENT*DW-1:0]        matIn,
  output logic                      invValid,
  output logic [3*DW+1:0]           detOut,
  output logic [NENT*(2*DW+1)-1:0]  adjOut
);

  localparam int TW   = 3 * DW;      // triple product width
  localparam int DETW = 3 * DW + 2;  // determinant width
  localparam int CFW  = 2 * DW + 1;  // cofactor width

  logic [NENT-1:0][DW-1:0]  mRegP;
  logic [NENT-1:0][CFW-1:0] cofStageP;
  logic [NENT-1:0][CFW-1:0] adjP;

  logic signed [TW-1:0]   mulA    [NMUL];
  logic signed [DW-1:0]   mulB    [NMUL];
  logic signed [TW-1:0]   mulR    [NMUL];
  logic signed [TW-1:0]   pairReg [NMUL];
  logic signed [TW-1:0]   triReg  [NMUL];
  logic signed [TW-1:0]   prodReg [NMUL];

  logic signed [DETW-1:0] subA [NSUB];
  logic signed [DETW-1:0] subB [NSUB];
  logic signed [DETW-1:0] subR [NSUB];
  logic signed [DETW-1:0] addA [NADD];
  logic signed [DETW-1:0] addB [NADD];
  logic signed [DETW-1:0] addR [NADD];

  logic signed [DETW-1:0] posPairReg;  // t0 + t1
  logic signed [DETW-1:0] negPairReg;  // t3 + t4
  logic signed [DETW-1:0] crossReg;    // t2 - t5
  logic signed [DETW-1:0] posRestReg;  // t0 + t1 + t2 - t5
  logic signed [DETW-1:0] detReg;
  logic                   validReg;
  logic                   cofMulStep;
  logic                   cofSubStep;

  // ---------------------------------------------------------------
  // shared functional unit pool
  // ---------------------------------------------------------------
  for (genvar u = 0; u < NMUL; u++) begin : g_mulPool
    mtxinv_fu #(.KIND(FU_MUL), .AW(TW), .BW(DW), .RW(TW)) u_fu (
      .opA(mulA[u]), .opB(mulB[u]), .res(mulR[u]));
  end
  for (genvar u = 0; u < NSUB; u++) begin : g_subPool
    mtxinv_fu #(.KIND(FU_SUB), .AW(DETW), .BW(DETW), .RW(DETW)) u_fu (
      .opA(subA[u]), .opB(subB[u]), .res(subR[u]));
  end
  for (genvar u = 0; u < NADD; u++) begin : g_addPool
    mtxinv_fu #(.KIND(FU_ADD), .AW(DETW), .BW(DETW), .RW(DETW)) u_fu (
      .opA(addA[u]), .opB(addB[u]), .res(addR[u]));
  end

  // ---------------------------------------------------------------
  // operand routing per control step
  // ---------------------------------------------------------------
  always_comb begin
    cofMulStep = 1'b0;
    cofSubStep = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (strb.stepHot[STEP_G0 + g])     cofMulStep = 1'b1;
      if (strb.stepHot[STEP_G0 + 1 + g]) cofSubStep = 1'b1;
    end
  end

  always_comb begin
    for (int u = 0; u < NMUL; u++) begin
      mulA[u] = '0;
      mulB[u] = '0;
      if (strb.stepHot[STEP_PAIR]) begin
        mulA[u] = TW'($signed(mRegP[triIdx(u, 0)]));
        mulB[u] = $signed(mRegP[triIdx(u, 1)]);
      end else if (strb.stepHot[STEP_TRI]) begin
        mulA[u] = pairReg[u];
        mulB[u] = $signed(mRegP[triIdx(u, 2)]);
      end
      for (int g = 0; g < NGRP; g++) begin
        if (strb.stepHot[STEP_G0 + g]) begin
          mulA[u] = TW'($signed(mRegP[cofIdx(NDIM * g + u / 2, 2 * (u % 2))]));
          mulB[u] = $signed(mRegP[cofIdx(NDIM * g + u / 2, 2 * (u % 2) + 1)]);
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NSUB; k++) begin
      subA[k] = '0;
      subB[k] = '0;
      if (cofSubStep) begin
        subA[k] = DETW'(prodReg[2 * k]);
        subB[k] = DETW'(prodReg[2 * k + 1]);
      end
    end
    if (strb.stepHot[STEP_G0]) begin
      subA[0] = DETW'(triReg[2]);
      subB[0] = DETW'(triReg[5]);
    end else if (strb.stepHot[NSTEP]) begin
      subA[0] = posRestReg;
      subB[0] = negPairReg;
    end
  end

  always_comb begin
    for (int k = 0; k < NADD; k++) begin
      addA[k] = '0;
      addB[k] = '0;
    end
    if (strb.stepHot[STEP_G0]) begin
      addA[0] = DETW'(triReg[0]);
      addB[0] = DETW'(triReg[1]);
      addA[1] = DETW'(triReg[3]);
      addB[1] = DETW'(triReg[4]);
    end
    if (strb.stepHot[STEP_G0 + 1]) begin
      addA[2] = posPairReg;
      addB[2] = crossReg;
    end
  end

  // ---------------------------------------------------------------
  // result registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mRegP      <= '0;
      cofStageP  <= '0;
      adjP       <= '0;
      posPairReg <= '0;
      negPairReg <= '0;
      crossReg   <= '0;
      posRestReg <= '0;
      detReg     <= '0;
      validReg   <= 1'b0;
      for (int u = 0; u < NMUL; u++) begin
        pairReg[u] <= '0;
        triReg[u]  <= '0;
        prodReg[u] <= '0;
      end
    end else begin
      if (strb.load) mRegP <= matIn;
      for (int u = 0; u < NMUL; u++) begin
        if (strb.stepHot[STEP_PAIR]) pairReg[u] <= mulR[u];
        if (strb.stepHot[STEP_TRI])  triReg[u]  <= mulR[u];
        if (cofMulStep)              prodReg[u] <= mulR[u];
      end
      if (strb.stepHot[STEP_G0]) begin
        posPairReg <= addR[0];
        negPairReg <= addR[1];
        crossReg   <= subR[0];
      end
      if (strb.stepHot[STEP_G0 + 1]) posRestReg <= addR[2];
      for (int g = 0; g < NGRP; g++) begin
        if (strb.stepHot[STEP_G0 + 1 + g]) begin
          for (int k = 0; k < NSUB; k++) begin
            cofStageP[NDIM * g + k] <= subR[k][CFW-1:0];
          end
        end
      end
      if (strb.stepHot[NSTEP]) begin
        detReg <= subR[0];
        if (subR[0] > 0) begin
          validReg <= 1'b1;
          for (int i = 0; i < NDIM; i++) begin
            for (int j = 0; j < NDIM; j++) begin
              adjP[NDIM * i + j] <= cofStageP[NDIM * j + i];
            end
          end
        end else begin
          validReg <= 1'b0;
        end
      end
    end
  end

  assign invValid = validReg;
  assign detOut   = detReg;
  assign adjOut   = adjP;

  AST_INPUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(mRegP)); // R2
  AST_VALID_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    validReg |-> (detReg > 0)); // R6
  AST_ADJ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepHot[NSTEP] && (subR[0] <= 0)) |=> $stable(adjP)); // R7
  for (genvar k = 0; k < NSUB; k++) begin : g_fitChk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      cofSubStep |-> (subR[k] == DETW'($signed(subR[k][CFW-1:0])))); // R8
  end

endmodule

// File: rtl/mtxinv_core.sv
module mtxinv_core
  import mtxinv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [NENT*DW-1:0]        matIn,
  output logic                      done,
  output logic                      invValid,
  output logic [3*DW+1:0]           detOut,
  output logic [NENT*(2*DW+1)-1:0]  adjOut
);

  ctrlStrb_t strb;

  mtxinv_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  mtxinv_dpath #(.DW(DW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .matIn    (matIn),
    .invValid (invValid),
    .detOut   (detOut),
    .adjOut   (adjOut)
  );

endmodule

// File: tb/mtxinv_core_tb.sv
`timescale 1ns/1ps
module mtxinv_core_tb_top;

  localparam int DW   = 8;
  localparam int CFW  = 2 * DW + 1;
  localparam int DETW = 3 * DW + 2;
  localparam int MW   = 9 * DW;
  localparam int AW   = 9 * CFW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] matIn = '0;
  logic          done;
  logic          invValid;
  logic [DETW-1:0] detOut;
  logic [AW-1:0]   adjOut;

  always #2 clk = ~clk;  // 250 MHz

  mtxinv_core #(.DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .matIn(matIn),
    .done(done), .invValid(invValid), .detOut(detOut), .adjOut(adjOut));

  int    nChecks = 0;
  int    nErrors = 0;
  string curTag  = "R1";

  // ---------------- behavioural reference model ----------------
  int          mStep;
  bit          mDone;
  bit          mValid;
  int          mDet;
  logic [AW-1:0] mAdj;
  bit          mHeld;      // last completion had a non-positive determinant
  int          cap [3][3];

  function automatic int refCof(input int r, input int c);
    int ra = (r + 1) % 3, rb = (r + 2) % 3, ca = (c + 1) % 3, cb = (c + 2) % 3;
    return cap[ra][ca] * cap[rb][cb] - cap[ra][cb] * cap[rb][ca];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStep = 0; mDone = 0; mValid = 0; mDet = 0; mAdj = '0; mHeld = 0;
    end else begin
      mDone = 0;
      if (mStep == 0) begin
        if (start) begin
          for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
              cap[r][c] = $signed(matIn[DW*(3*r+c) +: DW]);
          mStep = 1;
        end
      end else if (mStep == 7) begin
        mDet = 0;
        for (int c = 0; c < 3; c++) mDet += cap[0][c] * refCof(0, c);
        if (mDet > 0) begin
          mValid = 1; mHeld = 0;
          for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
              mAdj[CFW*(3*i+j) +: CFW] = CFW'(refCof(j, i));
        end else begin
          mValid = 0; mHeld = 1;
        end
        mDone = 1;
        mStep = 0;
      end else begin
        mStep++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s [%s] %s actual %0d expected %0d", req, curTag, what, act, exp);
    end
  endtask

  task automatic chkAdj(input string req);
    nChecks++;
    if (adjOut !== mAdj) begin
      nErrors++;
      $display("FAIL %s [%s] adjOut actual %h expected %h", req, curTag, adjOut, mAdj);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(done === mDone, "R3", "done", longint'(done), longint'(mDone));
      chk($signed(detOut) == mDet, "R5", "detOut", longint'($signed(detOut)), longint'(mDet));
      chk(invValid === mValid, "R6", "invValid", longint'(invValid), longint'(mValid));
      chkAdj(mHeld ? "R7" : "R6");
    end
  end

  function automatic logic [MW-1:0] mk(input int e [9]);
    logic [MW-1:0] v;
    for (int k = 0; k < 9; k++) v[DW*k +: DW] = DW'(e[k]);
    return v;
  endfunction

  task automatic runOne(input logic [MW-1:0] m, input string tag,
                        input bit scramble, input bit holdStart);
    curTag = tag;
    matIn  = m;
    start  = 1'b1;
    @(negedge clk);
    if (!holdStart) start = 1'b0;
    if (scramble) matIn = ~m;
    repeat (8) @(negedge clk);
    start = 1'b0;
    if (holdStart) repeat (9) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    nErrors++;
    $display("FAIL R3 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin : stimulus
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    curTag = "R1";
    chk(done == 1'b0, "R1", "done", longint'(done), 0);
    chk(invValid == 1'b0, "R1", "invValid", longint'(invValid), 0);
    chk(detOut == '0, "R1", "detOut", longint'(detOut), 0);
    chk(adjOut == '0, "R1", "adjOut nonzero", longint'(|adjOut), 0);

    runOne(mk('{1,0,0, 0,1,0, 0,0,1}), "R6", 0, 0);
    runOne(mk('{2,-1,0, -1,2,-1, 0,-1,2}), "R5", 0, 0);
    runOne(mk('{3,1,4, 1,5,9, 2,6,5}), "R7", 0, 0);        // negative
    runOne(mk('{1,2,3, 4,5,6, 7,8,9}), "R7", 0, 0);        // zero
    runOne(mk('{4,7,2, 3,6,1, 2,5,3}), "R6", 0, 0);
    runOne(mk('{-128,0,0, 0,-128,0, 0,0,127}), "R8", 0, 0);
    runOne(mk('{127,-128,-128, -128,127,-128, -128,-128,127}), "R8", 0, 0);
    runOne(mk('{-128,-128,-128, -128,-128,-128, -128,-128,-128}), "R8", 0, 0);
    runOne(mk('{127,-128,127, 127,127,-128, -128,127,127}), "R8", 0, 0);
    runOne(mk('{5,-3,2, 1,4,-6, -2,7,3}), "R2", 1, 0);     // inputs scrambled mid-run
    runOne(mk('{6,1,0, -2,5,3, 1,-4,7}), "R4", 0, 1);      // start held through run
    runOne(mk('{9,2,-1, 3,8,4, -5,2,6}), "R4", 1, 1);

    for (int n = 0; n < 150; n++) begin
      logic [MW-1:0] m;
      for (int k = 0; k < 9; k++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        m[DW*k +: DW] = seed[23:16];
      end
      runOne(m, "R5", seed[3], seed[7] & seed[9]);
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule